// File: doc/BRIEF.md
# Manual Reset Input Conditioner

This block takes an active-low reset request from a front-panel switch or from external logic and turns it into a clean, synchronous reset request for the downstream reset generator. The raw pin is first brought into the system clock domain through a chain of flops. The block then measures how long the synchronized level stays low, using a millisecond tick from a free-running clock divider. A low that lasts long enough is accepted and the request rises. A low that is too short, or that bounces back high, is discarded.

The acceptance point is set in whole milliseconds by `ACCEPT_MS`, which is kept between 2 and 19. With that range, a low shorter than 1 ms can never be accepted, and a low of 20 ms or more always is. The release uses the same rule in the opposite direction: the request falls only after the synchronized input has stayed high for `ACCEPT_MS` ticks. Stretching the reset after release is left to the downstream generator.

Top module: `mrstFilter`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `rstReq` is 0. The internal state resets to idle, and the synchronizer loads the inactive level (1).
- R2: While `btnN` is held high (1 = released), `rstReq` never rises.
- R3: A low pulse on `btnN` shorter than `CLKS_PER_MS` clock cycles (1 ms) never raises `rstReq`.
- R4: A continuous low raises `rstReq` once the synchronized low has spanned `ACCEPT_MS` millisecond ticks. The request therefore rises no earlier than `(ACCEPT_MS-1)*CLKS_PER_MS` cycles after the input falls, and no later than `ACCEPT_MS*CLKS_PER_MS+4` cycles after it falls.
- R5: A low held for 20 ms (`20*CLKS_PER_MS` cycles) always leaves `rstReq` at 1.
- R6: A single high sample while a low is being measured restarts the measurement from zero. Bouncing lows that are each shorter than `ACCEPT_MS-1` ms never raise the request.
- R7: `rstReq` stays at 1 while the input remains low. It falls only after the synchronized input has been high for `ACCEPT_MS` ticks. A low sample during this high interval restarts the release measurement.
- R8: `btnN` passes through two flops before it is filtered, so a change on the pin cannot affect `rstReq` within the next two clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| btnN | input | 1 | Raw active-low manual reset input; idles high |
| rstReq | output | 1 | Filtered reset request, active high |

## Verification
Two events can fall in the same cycle: a millisecond tick and a bounce, meaning a synchronized sample of the opposite level. In that cycle the clear must win over the increment. The bench provokes this with glitch trains of different spacings that sweep the glitch position across the tick phase, both while a low is being measured and while a release is being measured. A behavioural reference model driven by a cycle counter and a sample queue is compared with `rstReq` on every clock. If the clear and the tick were mishandled, the request would rise or fall one tick early, and the comparison would catch it.

// File: rtl/mrstFilterPkg.sv
package mrstFilterPkg;
  // strobes from control to the duration datapath
  typedef struct packed {
    logic clr;
    logic inc;
  } runCtlT;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HELD = 1'b1
  } filtStateT;
endpackage

// File: rtl/mrstFilterDp.sv
module mrstFilterDp
  import mrstFilterPkg::*;
#(
  parameter int CLKS_PER_MS = 100000,
  parameter int ACCEPT_MS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   btnN,
  input  runCtlT runCtl,
  output logic   syncLow,
  output logic   tick,
  output logic   runDone
);
  localparam int DIV_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam int RUN_W = $clog2(ACCEPT_MS + 1);
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(CLKS_PER_MS - 1);
  localparam logic [RUN_W-1:0] RUN_LIMIT = RUN_W'(ACCEPT_MS);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [DIV_W-1:0]       divCnt;
  logic [RUN_W-1:0]       runCnt;

  // synchronizer chain, resets to the idle (high) level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], btnN};
  end
  assign syncLow = ~syncQ[SYNC_STAGES-1];

  // free-running millisecond divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end
  assign tick = (divCnt == DIV_LAST);

  // duration counter in ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           runCnt <= '0;
    else if (runCtl.clr) runCnt <= '0;
    else if (runCtl.inc) runCnt <= runCnt + 1'b1;
  end
  assign runDone = (runCnt == RUN_LIMIT);

  p_tick_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (divCnt == '0));

  p_bounce_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    runCtl.clr |=> (runCnt == '0));

  p_run_bounded_r4: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= RUN_LIMIT);
endmodule

// File: rtl/mrstFilterCtrl.sv
module mrstFilterCtrl
  import mrstFilterPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   syncLow,
  input  logic   tick,
  input  logic   runDone,
  output runCtlT runCtl,
  output logic   rstReq
);
  filtStateT state;
  logic      levelMatch;

  // idle measures lows, held measures highs
  assign levelMatch = (state == ST_HELD) ? ~syncLow : syncLow;

  always_comb begin
    runCtl.clr = ~levelMatch | runDone;
    runCtl.inc = levelMatch & tick & ~runDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        state <= ST_IDLE;
    else if (runDone) state <= (state == ST_HELD) ? ST_IDLE : ST_HELD;
  end

  assign rstReq = (state == ST_HELD);

  p_rise_after_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReq) |-> $past(syncLow));

  p_fall_after_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstReq) |-> $past(~syncLow));

  p_done_toggles_r7: assert property (@(posedge clk) disable iff (!rstN)
    runDone |=> (rstReq != $past(rstReq)));
endmodule

// File: rtl/mrstFilter.sv
module mrstFilter #(
  parameter int CLKS_PER_MS = 100000,
  parameter int ACCEPT_MS   = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic btnN,
  output logic rstReq
);
  import mrstFilterPkg::*;

  runCtlT runCtl;
  logic   syncLow;
  logic   tick;
  logic   runDone;

  mrstFilterDp #(
    .CLKS_PER_MS(CLKS_PER_MS),
    .ACCEPT_MS  (ACCEPT_MS),
    .SYNC_STAGES(2)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .btnN   (btnN),
    .runCtl (runCtl),
    .syncLow(syncLow),
    .tick   (tick),
    .runDone(runDone)
  );

  mrstFilterCtrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .syncLow(syncLow),
    .tick   (tick),
    .runDone(runDone),
    .runCtl (runCtl),
    .rstReq (rstReq)
  );
endmodule

// File: tb/test_mrstFilter.sv
module test_mrstFilter;
  localparam int CPM = 20;
  localparam int ACC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic btnN = 1'b1;
  logic rstReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mrstFilter #(.CLKS_PER_MS(CPM), .ACCEPT_MS(ACC)) i_mrstFilter (
    .clk(clk), .rstN(rstN), .btnN(btnN), .rstReq(rstReq)
  );

  // behavioural reference model
  bit pinHist[$];
  int cycleSinceRst;
  int spanTicks;
  bit mReq;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinHist = '{1'b1, 1'b1};
      cycleSinceRst = 0;
      spanTicks = 0;
      mReq = 1'b0;
    end else begin
      bit seenHigh;
      bit tickNow;
      bit wanted;
      seenHigh = pinHist[0];
      tickNow = ((cycleSinceRst % CPM) == CPM - 1);
      wanted = mReq ? seenHigh : !seenHigh;
      if (spanTicks == ACC) begin
        mReq = !mReq;
        spanTicks = 0;
      end else if (!wanted) spanTicks = 0;
      else if (tickNow) spanTicks++;
      cycleSinceRst++;
      void'(pinHist.pop_front());
      pinHist.push_back(btnN);
    end
  end

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R4, R7)
  always @(negedge clk) begin
    if (rstN && !done) check(rstReq == mReq, "R4/R7 model", rstReq, mReq);
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int rise;
    rstN = 1'b0;
    btnN = 1'b1;
    waitCyc(3);
    check(rstReq == 1'b0, "R1 in reset", rstReq, 0);
    rstN = 1'b1;
    waitCyc(1);
    check(rstReq == 1'b0, "R1 after reset", rstReq, 0);

    // R2: idle high
    waitCyc(300);
    check(rstReq == 1'b0, "R2 idle", rstReq, 0);

    // R3: short lows of various lengths
    for (int len = 1; len < CPM; len += 6) begin
      btnN = 1'b0; waitCyc(len);
      btnN = 1'b1; waitCyc(60);
      check(rstReq == 1'b0, "R3 short pulse", rstReq, 0);
    end

    // R8: change cannot reach output within two edges
    btnN = 1'b0; waitCyc(2);
    check(rstReq == 1'b0, "R8 sync latency", rstReq, 0);
    btnN = 1'b1; waitCyc(100);

    // R4: recognition window
    btnN = 1'b0;
    rise = -1;
    for (int c = 1; c <= ACC * CPM + 4; c++) begin
      waitCyc(1);
      if (rstReq && rise < 0) rise = c;
    end
    check(rise >= (ACC - 1) * CPM, "R4 not too early", rise, (ACC - 1) * CPM);
    check(rise > 0 && rise <= ACC * CPM + 4, "R4 not too late", rise, ACC * CPM + 4);

    // R7: stays while low, release needs a sustained high
    waitCyc(200);
    check(rstReq == 1'b1, "R7 held while low", rstReq, 1);
    for (int k = 0; k < 6; k++) begin
      btnN = 1'b1; waitCyc(45);
      btnN = 1'b0; waitCyc(1 + k);
    end
    check(rstReq == 1'b1, "R7 bounce on release", rstReq, 1);
    btnN = 1'b1; waitCyc(ACC * CPM + 6);
    check(rstReq == 1'b0, "R7 released", rstReq, 0);
    waitCyc(50);

    // R6: bouncing low, glitch spacing swept across the tick phase
    for (int sp = 41; sp <= 55; sp += 7) begin
      for (int k = 0; k < 10; k++) begin
        btnN = 1'b0; waitCyc(sp);
        btnN = 1'b1; waitCyc(1);
      end
      check(rstReq == 1'b0, "R6 bounce restarts", rstReq, 0);
    end
    waitCyc(30);

    // R5: 20 ms low always accepted
    btnN = 1'b0; waitCyc(20 * CPM);
    check(rstReq == 1'b1, "R5 long low", rstReq, 1);
    btnN = 1'b1; waitCyc(ACC * CPM + 6);
    check(rstReq == 1'b0, "R7 final release", rstReq, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule